// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block turns up to 24 external interrupt pins into interrupt messages for processor cores. Each pin owns a 64-bit redirection entry. The entry sets the vector, the delivery mode, physical or logical addressing, the destination, the active polarity, edge or level detection, and a mask. A detected request is held as pending in the entry. The block raises one message at a time on a ready/valid output and holds that message until the downstream side accepts it.

Software never addresses an entry directly. It first writes a register index into a select register at offset 0x00. It then reads or writes the 32-bit data window at offset 0x10. Index 0x00 is the identification register. Entries start at index 0x10 and use two consecutive indexes each: the low word at 0x10+2n and the high word at 0x10+2n+1. Level-mode pins are stopped from firing again by a per-entry in-service flag. An end-of-interrupt input carrying the matching vector clears that flag.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry is masked, so its low word reads 0x0001_0000 and its high word reads 0. The ID reads 0 and msg_valid is low.
- R2: Register access goes through the select register and the data window. Low-word layout: vector [7:0], delivery mode [10:8], logical-destination bit [11], read-only delivery status [12], polarity [13], read-only in-service flag [14], level-trigger bit [15], mask [16]. High-word layout: destination [31:24]. All other bits read 0.
- R3: At index 0x00 the 4-bit ID sits at bits 27:24 and every other bit reads 0. Indexes that are neither 0x00 nor an entry index read 0 and ignore writes.
- R4: An edge-mode pin latches exactly one request on each inactive-to-active transition. Holding the pin active produces no further request.
- R5: Polarity 0 means active high and polarity 1 means active low. With polarity 1 a falling input is the active transition.
- R6: A masked entry (mask bit = 1) latches nothing and sends nothing.
- R7: Delivery status reads 1 from the moment a request is latched until its message is accepted (msg_valid and msg_ready both high at a clock edge), and reads 0 after that. While msg_ready is low, the message stays valid and unchanged.
- R8: When several requests are pending, the lowest pin number is sent first.
- R9: In level mode, acceptance sets the in-service flag. No new request is made until eoi_valid arrives with eoi_vector equal to the entry's vector. After that, a pin that is still active requests again.
- R10: Delivery modes 4, 5 and 7 behave as edge mode whatever the level-trigger bit says. Their messages report msg_level = 0, and they never set the in-service flag.
- R11: Delivery modes 2 and 4 send a vector of 0. All other modes send the programmed vector.
- R12: Delivery modes 3 and 6 are reserved and never produce a message.
- R13: A message carries the entry's delivery mode, logical-destination bit, destination and pin number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset: 0x00 select, 0x10 window |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_pins | input | NUM_PINS | External interrupt inputs, synchronous to clk |
| msg_valid | output | 1 | Interrupt message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector sent |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | 1 means the destination is a logical mask |
| msg_dest | output | 8 | Destination field |
| msg_level | output | 1 | Effective level-trigger semantics of the message |
| msg_pin | output | PIN_W | Source pin of the message |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |

## Verification
Single-pin edge stimuli, in both polarities, show whether one transition gives exactly one message and whether a held level gives none. Two pins raised in the same cycle show whether the lowest pin wins. Level-mode stimuli use a mismatched end-of-interrupt vector and then the matching one, which separates a correctly qualified in-service clear from an unqualified one. Entries in the forced-edge, zero-vector and reserved delivery modes, each with its level bit set, show whether the mode overrides the trigger bit and the vector, or suppresses the message altogether.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;
    localparam int ID_W   = 4;

    // bus offsets and register indexes
    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_TBL  = 8'h10;

    // bit positions inside the 32-bit words
    localparam int B_MODE  = 8;
    localparam int B_LOGIC = 11;
    localparam int B_STAT  = 12;
    localparam int B_POL   = 13;
    localparam int B_INSV  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;
    localparam int B_DEST  = 24;
    localparam int B_ID    = 24;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMGT   = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMASK  = 3'd4,
        DM_START  = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXTERN = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;
        logic              pol;
        logic              logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vec;
    } entry_t;

    function automatic logic mode_forces_edge(dmode_e m);
        return (m == DM_NMASK) || (m == DM_START) || (m == DM_EXTERN);
    endfunction

    function automatic logic mode_reserved(dmode_e m);
        return (m == DM_RSV3) || (m == DM_RSV6);
    endfunction

    function automatic logic mode_zero_vec(dmode_e m);
        return (m == DM_SMGT) || (m == DM_NMASK);
    endfunction

endpackage

// File: rtl/irt_pin_detect.sv
module irt_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic active_low,
    output logic act_o,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        act_o  = pin_in ^ active_low;
        rise_o = act_o & ~prev_q;
        prev_d = act_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irt_lowest_first.sv
module irt_lowest_first #(
    parameter int N  = 24,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pins,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic                msg_logical,
    output logic [7:0]          msg_dest,
    output logic                msg_level,
    output logic [PIN_W-1:0]    msg_pin,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);
    localparam int TBL_END = int'(IDX_TBL) + 2 * NUM_PINS;

    typedef struct packed {
        logic [7:0]                sel;
        logic [ID_W-1:0]           id;
        entry_t [NUM_PINS-1:0]     ent;
        logic [NUM_PINS-1:0]       pend;
        logic [NUM_PINS-1:0]       insv;
        logic                      vld;
        logic [PIN_W-1:0]          pin;
        logic [VEC_W-1:0]          vec;
        dmode_e                    mode;
        logic                      logical;
        logic [DEST_W-1:0]         dest;
        logic                      level;
    } state_t;

    state_t st_d, st_q;

    // per-pin detection
    logic [NUM_PINS-1:0] act, rise;
    logic [NUM_PINS-1:0] pol_vec;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign pol_vec[g] = st_q.ent[g].pol;
        irt_pin_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_in    (irq_pins[g]),
            .active_low(pol_vec[g]),
            .act_o     (act[g]),
            .rise_o    (rise[g])
        );
    end

    // lowest pending pin
    logic             arb_any;
    logic [PIN_W-1:0] arb_idx;

    irt_lowest_first #(.N(NUM_PINS), .IW(PIN_W)) u_arb (
        .req  (st_q.pend),
        .any_o(arb_any),
        .idx_o(arb_idx)
    );

    // window decode
    logic [7:0]       win_off;
    logic             win_ent;
    logic             win_hi;
    logic [PIN_W-1:0] win_idx;

    always_comb begin
        win_off = st_q.sel - IDX_TBL;
        win_ent = (int'(st_q.sel) >= int'(IDX_TBL)) && (int'(st_q.sel) < TBL_END);
        win_hi  = win_off[0];
        win_idx = PIN_W'(win_off[7:1]);
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_SEL) begin
            bus_rdata[7:0] = st_q.sel;
        end else if (bus_addr == OFS_WIN) begin
            if (st_q.sel == IDX_ID) begin
                bus_rdata[B_ID +: ID_W] = st_q.id;
            end else if (win_ent) begin
                if (win_hi) begin
                    bus_rdata[B_DEST +: DEST_W] = st_q.ent[win_idx].dest;
                end else begin
                    bus_rdata[VEC_W-1:0]        = st_q.ent[win_idx].vec;
                    bus_rdata[B_MODE +: MODE_W] = st_q.ent[win_idx].mode;
                    bus_rdata[B_LOGIC]          = st_q.ent[win_idx].logical;
                    bus_rdata[B_STAT]           = st_q.pend[win_idx];
                    bus_rdata[B_POL]            = st_q.ent[win_idx].pol;
                    bus_rdata[B_INSV]           = st_q.insv[win_idx];
                    bus_rdata[B_TRIG]           = st_q.ent[win_idx].trig;
                    bus_rdata[B_MASK]           = st_q.ent[win_idx].mask;
                end
            end
        end
    end

    // next state
    always_comb begin
        logic edge_mode;
        logic req_set;
        st_d = st_q;

        // register writes
        if (bus_wr && bus_addr == OFS_SEL) begin
            st_d.sel = bus_wdata[7:0];
        end else if (bus_wr && bus_addr == OFS_WIN) begin
            if (st_q.sel == IDX_ID) begin
                st_d.id = bus_wdata[B_ID +: ID_W];
            end else if (win_ent) begin
                if (win_hi) begin
                    st_d.ent[win_idx].dest = bus_wdata[B_DEST +: DEST_W];
                end else begin
                    st_d.ent[win_idx].vec     = bus_wdata[VEC_W-1:0];
                    st_d.ent[win_idx].mode    = dmode_e'(bus_wdata[B_MODE +: MODE_W]);
                    st_d.ent[win_idx].logical = bus_wdata[B_LOGIC];
                    st_d.ent[win_idx].pol     = bus_wdata[B_POL];
                    st_d.ent[win_idx].trig    = bus_wdata[B_TRIG];
                    st_d.ent[win_idx].mask    = bus_wdata[B_MASK];
                end
            end
        end

        // end of interrupt clears the in-service flag of matching entries
        if (eoi_valid) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (st_q.ent[i].vec == eoi_vector) st_d.insv[i] = 1'b0;
            end
        end

        // output port: accept or load
        if (st_q.vld) begin
            if (msg_ready) begin
                st_d.vld           = 1'b0;
                st_d.pend[st_q.pin] = 1'b0;
                if (st_q.level) st_d.insv[st_q.pin] = 1'b1;
            end
        end else if (arb_any) begin
            st_d.vld     = 1'b1;
            st_d.pin     = arb_idx;
            st_d.mode    = st_q.ent[arb_idx].mode;
            st_d.logical = st_q.ent[arb_idx].logical;
            st_d.dest    = st_q.ent[arb_idx].dest;
            st_d.vec     = mode_zero_vec(st_q.ent[arb_idx].mode) ? '0 : st_q.ent[arb_idx].vec;
            st_d.level   = st_q.ent[arb_idx].trig && !mode_forces_edge(st_q.ent[arb_idx].mode);
        end

        // request latching
        for (int i = 0; i < NUM_PINS; i++) begin
            edge_mode = !st_q.ent[i].trig || mode_forces_edge(st_q.ent[i].mode);
            req_set   = !st_q.ent[i].mask && !mode_reserved(st_q.ent[i].mode) &&
                        (edge_mode ? rise[i]
                                   : (act[i] && !st_q.insv[i] && !st_q.pend[i]));
            if (req_set) st_d.pend[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) st_q.ent[i].mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid   = st_q.vld;
    assign msg_vector  = st_q.vec;
    assign msg_mode    = st_q.mode;
    assign msg_logical = st_q.logical;
    assign msg_dest    = st_q.dest;
    assign msg_level   = st_q.level;
    assign msg_pin     = st_q.pin;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_vector,
    input logic [2:0]       msg_mode,
    input logic             msg_level,
    input logic [7:0]       msg_dest,
    input logic [PIN_W-1:0] msg_pin
);
    // R7
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
        $stable(msg_dest) && $stable(msg_pin) && $stable(msg_mode));

    // R7
    msg_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    // R12
    no_reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_mode != 3'd3) && (msg_mode != 3'd6));

    // R11
    zero_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_mode == 3'd2 || msg_mode == 3'd4) |-> msg_vector == 8'd0);

    // R10
    forced_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_mode == 3'd4 || msg_mode == 3'd5 || msg_mode == 3'd7) |-> !msg_level);

    // R13
    pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> int'(msg_pin) < NUM_PINS);
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_vector(msg_vector),
    .msg_mode  (msg_mode),
    .msg_level (msg_level),
    .msg_dest  (msg_dest),
    .msg_pin   (msg_pin)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
    localparam int NP = 24;
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_pins = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector;
    logic [2:0]    msg_mode;
    logic          msg_logical;
    logic [7:0]    msg_dest;
    logic          msg_level;
    logic [PW-1:0] msg_pin;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_route_ctrl #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(irq_pins),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
        .msg_level(msg_level), .msg_pin(msg_pin), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] v);
        wr(8'h00, {24'h0, idx});
        bus_addr = 8'h10;
        #1 v = bus_rdata;
    endtask

    task automatic prog(input int p, input logic [31:0] lo, input logic [31:0] hi);
        wr(8'h00, 32'(8'h10 + 2 * p));
        wr(8'h10, lo);
        wr(8'h00, 32'(8'h10 + 2 * p + 1));
        wr(8'h10, hi);
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int i = 0; i < 10 && !got; i++) begin
            @(negedge clk);
            if (msg_valid) got = 1;
        end
    endtask

    task automatic accept;
        @(negedge clk) msg_ready = 1'b1;
        @(negedge clk) msg_ready = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic pin_set(input int p, input logic v);
        @(negedge clk) irq_pins[p] = v;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    // R1
    task automatic t_reset;
        logic [31:0] v;
        check("R1 valid", 32'(msg_valid), 0);
        rd_idx(8'h10, v); check("R1 entry0 low", v, 32'h0001_0000);
        rd_idx(8'h3E, v); check("R1 entry23 low", v, 32'h0001_0000);
        rd_idx(8'h3F, v); check("R1 entry23 high", v, 0);
        rd_idx(8'h00, v); check("R1 id", v, 0);
    endtask

    // R2 and R3
    task automatic t_regs;
        logic [31:0] v;
        prog(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_idx(8'h16, v); check("R2 low layout", v, 32'h0001_AFFF);
        rd_idx(8'h17, v); check("R2 high layout", v, 32'hFF00_0000);
        prog(3, 32'h0001_0000, 0);
        wr(8'h00, 0); wr(8'h10, 32'hFFFF_FFFF);
        rd_idx(8'h00, v); check("R3 id field", v, 32'h0F00_0000);
        wr(8'h00, 32'h05); wr(8'h10, 32'hFFFF_FFFF);
        rd_idx(8'h05, v); check("R3 hole index", v, 0);
        rd_idx(8'h40, v); check("R3 past table", v, 0);
        bus_addr = 8'h00; #1 check("R2 select readback", bus_rdata, 32'h40);
    endtask

    // R4 R7 R13
    task automatic t_edge;
        bit got; logic [31:0] v;
        prog(5, 32'h0000_0041, 32'h3C00_0000);
        pin_set(5, 1);
        wait_msg(got); check("R4 edge message", 32'(got), 1);
        check("R13 vector", 32'(msg_vector), 32'h41);
        check("R13 dest", 32'(msg_dest), 32'h3C);
        check("R13 pin", 32'(msg_pin), 5);
        rd_idx(8'h1A, v); check("R7 status pending", v, 32'h0000_1041);
        check("R7 still valid", 32'(msg_valid), 1);
        check("R7 held vector", 32'(msg_vector), 32'h41);
        accept;
        check("R7 dropped", 32'(msg_valid), 0);
        rd_idx(8'h1A, v); check("R7 status idle", v, 32'h0000_0041);
        quiet(6, "R4 held level no repeat");
        pin_set(5, 0);
    endtask

    // R5
    task automatic t_pol;
        bit got;
        pin_set(6, 1);
        prog(6, 32'h0000_2042, 32'h0100_0000);
        quiet(4, "R5 idle high inactive");
        pin_set(6, 0);
        wait_msg(got); check("R5 low active", 32'(got), 1);
        check("R5 vector", 32'(msg_vector), 32'h42);
        accept;
        pin_set(6, 1);
        quiet(5, "R5 release no message");
    endtask

    // R6
    task automatic t_mask;
        logic [31:0] v;
        pin_set(7, 1);
        quiet(5, "R6 masked silent");
        rd_idx(8'h1E, v); check("R6 no pending", v, 32'h0001_0000);
        pin_set(7, 0);
    endtask

    // R8
    task automatic t_order;
        bit got;
        prog(9, 32'h0000_0049, 0);
        prog(4, 32'h0000_0044, 0);
        @(negedge clk) begin irq_pins[9] = 1'b1; irq_pins[4] = 1'b1; end
        wait_msg(got); check("R8 first pin", 32'(msg_pin), 4);
        accept;
        wait_msg(got); check("R8 second pin", 32'(msg_pin), 9);
        check("R8 second vector", 32'(msg_vector), 32'h49);
        accept;
        @(negedge clk) begin irq_pins[9] = 1'b0; irq_pins[4] = 1'b0; end
    endtask

    // R9
    task automatic t_level;
        bit got; logic [31:0] v;
        prog(10, 32'h0000_8050, 0);
        pin_set(10, 1);
        wait_msg(got); check("R9 level message", 32'(got), 1);
        check("R9 msg_level", 32'(msg_level), 1);
        accept;
        rd_idx(8'h24, v); check("R9 in-service set", v, 32'h0000_C050);
        quiet(6, "R9 no re-request");
        eoi(8'h51);
        quiet(6, "R9 wrong eoi ignored");
        eoi(8'h50);
        wait_msg(got); check("R9 re-request after eoi", 32'(got), 1);
        accept;
        pin_set(10, 0);
        eoi(8'h50);
        quiet(6, "R9 inactive after eoi");
    endtask

    // R10 R11
    task automatic t_forced;
        bit got; logic [31:0] v;
        prog(11, 32'h0000_8477, 0);
        pin_set(11, 1);
        wait_msg(got); check("R10 forced edge message", 32'(got), 1);
        check("R10 reports edge", 32'(msg_level), 0);
        check("R11 mode4 vector zero", 32'(msg_vector), 0);
        accept;
        rd_idx(8'h26, v); check("R10 no in-service", v, 32'h0000_8477);
        quiet(5, "R10 held pin no repeat");
        pin_set(11, 0);
        prog(12, 32'h0000_0233, 0);
        pin_set(12, 1);
        wait_msg(got); check("R11 mode2 message", 32'(got), 1);
        check("R11 mode2 vector zero", 32'(msg_vector), 0);
        accept;
        pin_set(12, 0);
    endtask

    // R12
    task automatic t_reserved;
        prog(13, 32'h0000_0353, 0);
        prog(14, 32'h0000_0654, 0);
        @(negedge clk) begin irq_pins[13] = 1'b1; irq_pins[14] = 1'b1; end
        quiet(8, "R12 reserved silent");
        @(negedge clk) begin irq_pins[13] = 1'b0; irq_pins[14] = 1'b0; end
    endtask

    // R13
    task automatic t_logical;
        bit got;
        prog(15, 32'h0000_0961, 32'h8100_0000);
        pin_set(15, 1);
        wait_msg(got); check("R13 logical message", 32'(got), 1);
        check("R13 logical bit", 32'(msg_logical), 1);
        check("R13 mode", 32'(msg_mode), 1);
        check("R13 dest mask", 32'(msg_dest), 32'h81);
        check("R13 vector", 32'(msg_vector), 32'h61);
        accept;
        pin_set(15, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_edge;
        t_pol;
        t_mask;
        t_order;
        t_level;
        t_forced;
        t_reserved;
        t_logical;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule